// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. The line rests at logic high. A character begins with a low start bit, then carries 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The receiver runs on the system clock. It advances its bit timing only on cycles where a tick input is high, and that tick comes sixteen times per bit period from a rate generator outside the block. The serial input passes through a two-flop synchroniser before any logic looks at it.

When idle, a low level seen on a tick begins a start check. The line is tested again eight ticks later, and the start is accepted only if the line is still low; a shorter pulse is dropped. Each later bit is sampled sixteen ticks after the one before it, which places every sample near the bit centre. A finished character goes into a single holding register. A one-cycle strobe announces it, together with framing, parity, break and overrun flags that belong to that character. The host frees the register by pulsing `take_i`. A character that finishes while the register is still occupied is discarded, and the next character delivered carries the overrun flag. After a framing error or a break, the receiver waits for the line to go high before it looks for another start bit.

Top module: `async_rx`

## Requirements
- R1: After reset, `valid_o`, `data_o` and all four flag outputs are zero.
- R2: A low pulse on the line that is already high again at the eighth tick after it was first seen produces no character.
- R3: The data length is `MIN_W + len_sel_i` bits, so with defaults 00=5, 01=6, 10=7 and 11=8. Bits are taken LSB first into `data_o[0]` upward, and the unused upper bits of `data_o` are zero.
- R4: `par_sel_i` encodes 01 as even, 10 as odd, and 00 or 11 as no parity bit. With parity on, `parity_err_o` is set when data plus parity bit hold an odd count of ones (even mode) or an even count (odd mode). With parity off, it is never set.
- R5: `two_stop_i`=1 expects two stop bits and 0 expects one. `frame_err_o` is set when any stop sample is low.
- R6: When every sample of a character is low (data, parity if enabled, all stops), the character is delivered with `data_o`=0, `break_o`=1, `frame_err_o`=1 and `parity_err_o`=0.
- R7: After a framing error or break, a line that stays low produces no further character. Once the line returns high, the next frame is received normally.
- R8: A character that completes while the holding register is occupied and `take_i` is low is discarded. No strobe occurs and `data_o` keeps the held value. The next delivered character has `overrun_o`=1, and later ones have it at 0 again.
- R9: `valid_o` is high for exactly one cycle per delivered character, and `data_o` and the flags stay unchanged until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Strobe at sixteen times the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idles high |
| len_sel_i | input | LEN_W | Data length select, length = MIN_W + value |
| par_sel_i | input | 2 | 00/11 none, 01 even, 10 odd |
| two_stop_i | input | 1 | 1 expects two stop bits |
| take_i | input | 1 | Host frees the holding register |
| valid_o | output | 1 | One-cycle strobe for a new character |
| data_o | output | DATA_W | Held character, LSB first received |
| frame_err_o | output | 1 | A stop sample was low |
| parity_err_o | output | 1 | Parity mismatch |
| break_o | output | 1 | Whole frame read as zero |
| overrun_o | output | 1 | A character was lost before this one |

## Verification
The hardest situation to reach from the ports is the overrun path. It needs a character that finishes while the previous one is still held, and a check that the lost character leaves neither a strobe nor a change on `data_o`, followed by a delivered character that carries the flag. The bench reaches it directly by sending frames without pulsing `take_i`. Random frames cover all lengths, parity settings and stop counts, with parity and stop corruption added. A full-zero line held past the frame end drives the break and wait-for-high paths. A short low glitch drives the rejected-start path.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic frame_err;
    logic parity_err;
    logic brk;
  } rx_flags_t;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        RESET_LV = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RESET_LV;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RESET_LV}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_W  = 5,
  parameter int unsigned OSR    = 16,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        par_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output rx_flags_t         flags_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_e;

  st_e              state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic             stopn;
  logic [DATA_W-1:0] shreg;
  logic             par_acc;
  logic             all_zero;
  logic             stop_bad;

  logic [BW-1:0]    nbits;
  logic             par_en;
  logic             odd_mode;
  logic             smp;
  logic             bad_n;
  logic             az_n;
  logic             last_stop;
  logic [DATA_W-1:0] aligned;

  always_comb begin
    nbits     = BW'(MIN_W) + BW'(len_i);
    par_en    = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
    odd_mode  = (par_i == PAR_ODD);
    smp       = tick_i && (cnt == LAST);
    bad_n     = stop_bad | ~line_i;
    az_n      = all_zero & ~line_i;
    last_stop = ~two_stop_i | stopn;
    aligned   = shreg >> (BW'(DATA_W) - nbits);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      stopn    <= 1'b0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      all_zero <= 1'b1;
      stop_bad <= 1'b0;
      done_o   <= 1'b0;
      data_o   <= '0;
      flags_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick_i && !line_i) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (tick_i) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!line_i) begin
                state    <= S_DATA;
                bitn     <= '0;
                stopn    <= 1'b0;
                par_acc  <= 1'b0;
                all_zero <= 1'b1;
                stop_bad <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (smp) begin
            cnt      <= '0;
            shreg    <= {line_i, shreg[DATA_W-1:1]};
            par_acc  <= par_acc ^ line_i;
            all_zero <= az_n;
            bitn     <= bitn + 1'b1;
            if (bitn == nbits - 1'b1) state <= par_en ? S_PAR : S_STOP;
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (smp) begin
            cnt      <= '0;
            par_acc  <= par_acc ^ line_i;
            all_zero <= az_n;
            state    <= S_STOP;
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (smp) begin
            cnt      <= '0;
            stop_bad <= bad_n;
            all_zero <= az_n;
            if (!last_stop) begin
              stopn <= 1'b1;
            end else begin
              done_o             <= 1'b1;
              data_o             <= az_n ? '0 : aligned;
              flags_o.frame_err  <= bad_n;
              flags_o.brk        <= az_n;
              flags_o.parity_err <= par_en & ~az_n & (par_acc ^ odd_mode);
              state              <= bad_n ? S_WAITHI : S_IDLE;
            end
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAITHI: begin
          if (line_i) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: parity off never yields a parity error
  a_r4_no_par_err_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !par_en) |-> !flags_o.parity_err);

  // R7: stay parked while the line is low after a bad stop
  a_r7_wait_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_WAITHI && !line_i) |=> (state == S_WAITHI));

  // R2: a start rejected at mid-bit returns to idle
  a_r2_spurious_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_START && tick_i && cnt == MID && line_i) |=> (state == S_IDLE));
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  rx_flags_t         flags_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output rx_flags_t         flags_o,
  output logic              overrun_o
);
  logic full;
  logic pend_ovr;
  logic free;

  assign free = ~full | take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full      <= 1'b0;
      pend_ovr  <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= '0;
      flags_o   <= '0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i && free) begin
        full      <= 1'b1;
        valid_o   <= 1'b1;
        data_o    <= data_i;
        flags_o   <= flags_i;
        overrun_o <= pend_ovr;
        pend_ovr  <= 1'b0;
      end else if (done_i) begin
        pend_ovr <= 1'b1;
      end else if (take_i) begin
        full <= 1'b0;
      end
    end
  end

  // R9: strobe lasts one cycle
  a_r9_one_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9: held character stable between deliveries
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // R8: a lost character raises no strobe and keeps the held value
  a_r8_lost_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full && !take_i) |=> (!valid_o && $stable(data_o)));

  // R6: break arrives as zero data with framing error and no parity error
  a_r6_break_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o.brk) |-> (flags_o.frame_err && !flags_o.parity_err && data_o == '0));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_W  = 5,
  parameter int unsigned OSR    = 16,
  parameter int unsigned LEN_W  = $clog2(DATA_W - MIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              two_stop_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              break_o,
  output logic              overrun_o
);
  logic              line_s;
  logic              done;
  logic [DATA_W-1:0] fr_data;
  rx_flags_t         fr_flags;
  rx_flags_t         hold_flags;

  async_rx_sync #(.STAGES(2), .RESET_LV(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (line_s)
  );

  async_rx_frame #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OSR(OSR), .LEN_W(LEN_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .len_i      (len_sel_i),
    .par_i      (par_sel_i),
    .two_stop_i (two_stop_i),
    .done_o     (done),
    .data_o     (fr_data),
    .flags_o    (fr_flags)
  );

  async_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (fr_data),
    .flags_i   (fr_flags),
    .take_i    (take_i),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .flags_o   (hold_flags),
    .overrun_o (overrun_o)
  );

  assign frame_err_o  = hold_flags.frame_err;
  assign parity_err_o = hold_flags.parity_err;
  assign break_o      = hold_flags.brk;

  // R3: bits above the configured length are zero
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> (MIN_W + 32'(len_sel_i))) == '0));
endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
  localparam int BIT = 32;  // clocks per bit: tick every 2 clocks, 16 ticks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] len_sel_i = 2'b11;
  logic [1:0] par_sel_i = 2'b00;
  logic       two_stop_i = 1'b0;
  logic       take_i = 1'b0;
  logic       valid_o;
  logic [7:0] data_o;
  logic       frame_err_o, parity_err_o, break_o, overrun_o;

  int n_chk = 0;
  int n_fail = 0;
  int vcnt = 0;

  always #4 clk_i = ~clk_i;

  async_rx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .len_sel_i(len_sel_i), .par_sel_i(par_sel_i), .two_stop_i(two_stop_i),
    .take_i(take_i), .valid_o(valid_o), .data_o(data_o),
    .frame_err_o(frame_err_o), .parity_err_o(parity_err_o),
    .break_o(break_o), .overrun_o(overrun_o)
  );

  initial forever begin
    @(negedge clk_i);
    tick_i = ~tick_i;
  end

  initial forever begin
    @(negedge clk_i);
    if (valid_o) vcnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    rxd_i = b;
    repeat (BIT) @(negedge clk_i);
  endtask

  task automatic pulse_take();
    @(negedge clk_i) take_i = 1'b1;
    @(negedge clk_i) take_i = 1'b0;
  endtask

  function automatic logic [7:0] mask_of(input int len);
    return 8'((9'd1 << len) - 9'd1);
  endfunction

  function automatic logic par_bit(input logic [7:0] m, input logic [1:0] pm, input bit bad);
    return (^m) ^ (pm == 2'b10) ^ bad;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int len, input logic [1:0] pm,
                            input bit two, input bit bad_par, input bit bad_stop);
    logic [7:0] m;
    m = d & mask_of(len);
    drive(1'b0);
    for (int i = 0; i < len; i++) drive(d[i]);
    if (pm == 2'b01 || pm == 2'b10) drive(par_bit(m, pm, bad_par));
    drive(!bad_stop);
    if (two) drive(!bad_stop);
    rxd_i = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] lsel, input logic [1:0] pm,
                           input bit two, input bit bp, input bit bs, input bit exp_ovr);
    int len, v0;
    bit pen, az;
    logic [7:0] m;
    len = 5 + int'(lsel);
    pen = (pm == 2'b01 || pm == 2'b10);
    m = d & mask_of(len);
    if (!pen) bp = 1'b0;
    az = (m == 8'h00) && (!pen || par_bit(m, pm, bp) == 1'b0) && bs;
    len_sel_i = lsel; par_sel_i = pm; two_stop_i = two;
    v0 = vcnt;
    send_frame(d, len, pm, two, bp, bs);
    chk("R9 strobe count", vcnt - v0, 1);
    chk("R3 data", int'(data_o), int'(m));
    chk("R4 parity_err", int'(parity_err_o), int'(pen && !az && bp));
    chk("R5 frame_err", int'(frame_err_o), int'(bs));
    chk("R6 break", int'(break_o), int'(az));
    chk("R8 overrun", int'(overrun_o), int'(exp_ovr));
    pulse_take();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R9 watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v0;
    void'($urandom(32'h1f2e3d4c));
    repeat (5) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 data", int'(data_o), 0);
    chk("R1 flags", int'({frame_err_o, parity_err_o, break_o, overrun_o}), 0);
    rst_ni = 1'b1;
    repeat (BIT) @(negedge clk_i);

    // directed: each length, each parity mode
    run_frame(8'hA5, 2'b11, 2'b00, 1'b0, 0, 0, 0);
    run_frame(8'hFF, 2'b00, 2'b01, 1'b0, 0, 0, 0);
    run_frame(8'h2D, 2'b01, 2'b10, 1'b1, 0, 0, 0);
    run_frame(8'h5A, 2'b10, 2'b01, 1'b0, 1, 0, 0);  // R4 even mismatch
    run_frame(8'h00, 2'b11, 2'b10, 1'b0, 1, 0, 0);  // R4 odd mismatch
    run_frame(8'h81, 2'b11, 2'b11, 1'b1, 0, 1, 0);  // R5 bad stop

    // R2 spurious start
    v0 = vcnt;
    rxd_i = 1'b0; repeat (12) @(negedge clk_i);
    rxd_i = 1'b1; repeat (2 * BIT) @(negedge clk_i);
    chk("R2 glitch no strobe", vcnt - v0, 0);
    run_frame(8'h3C, 2'b11, 2'b00, 1'b0, 0, 0, 0);

    // R6/R7 break held low well past frame end
    len_sel_i = 2'b11; par_sel_i = 2'b01; two_stop_i = 1'b1;
    v0 = vcnt;
    rxd_i = 1'b0; repeat (16 * BIT) @(negedge clk_i);
    chk("R7 one char while low", vcnt - v0, 1);
    chk("R6 break flag", int'(break_o), 1);
    chk("R6 break frame_err", int'(frame_err_o), 1);
    chk("R6 break data", int'(data_o), 0);
    chk("R6 break parity_err", int'(parity_err_o), 0);
    rxd_i = 1'b1; repeat (2 * BIT) @(negedge clk_i);
    pulse_take();
    run_frame(8'hC3, 2'b11, 2'b01, 1'b1, 0, 0, 0);  // R7 recovers

    // R8 overrun
    len_sel_i = 2'b11; par_sel_i = 2'b00; two_stop_i = 1'b0;
    v0 = vcnt;
    send_frame(8'h11, 8, 2'b00, 1'b0, 0, 0);
    chk("R8 first delivered", vcnt - v0, 1);
    send_frame(8'h22, 8, 2'b00, 1'b0, 0, 0);
    chk("R8 lost no strobe", vcnt - v0, 1);
    chk("R8 held data kept", int'(data_o), 8'h11);
    chk("R9 held overrun clear", int'(overrun_o), 0);
    pulse_take();
    run_frame(8'h33, 2'b11, 2'b00, 1'b0, 0, 0, 1);
    run_frame(8'h44, 2'b11, 2'b00, 1'b0, 0, 0, 0);

    // random frames
    for (int k = 0; k < 120; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom % 8 == 0) d = 8'h00;
      run_frame(d, 2'($urandom), 2'($urandom), 1'($urandom),
                ($urandom % 4 == 0), ($urandom % 6 == 0), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule